// File: doc/BRIEF.md
# Stride-Three Wrapping Counter

This block is a small binary counter that moves forward by three codes on every rising clock edge for which its enable input is high. The sum is simply truncated to the counter width, so a 3-bit count wraps modulo eight. Because three and eight share no factor, the count passes through every one of the eight codes before it repeats.

An active-high reset clears the count to zero as soon as it rises, without waiting for a clock edge. It also outranks the enable. Typical uses are interleaved index generation and the stepping of a pointer with a coprime stride.

Internally a small decoder turns the inputs into one of two named operations, `OP_HOLD` or `OP_STEP`. The state is the count itself, which is one of the codes 0 to 7. The transitions are:

- **step**: in `OP_STEP`, a rising edge moves the count from c to (c+3) mod 8.
- **hold**: in `OP_HOLD`, a rising edge leaves c unchanged.
- **clear**: a high reset moves the count from any state to 0, asynchronously.

Top module: `stride3_counter`

## Requirements
- R1: While `rst_i` is high, `cnt_o` is 000. When reset rises in the middle of a clock period, the output reads 000 before the next rising edge.
- R2: A rising edge while `rst_i` is high leaves `cnt_o` at 000, even when `en_i` is high.
- R3: With `rst_i` low and `en_i` high, a rising edge sets `cnt_o` to (previous + 3) mod 8. For example, 111→010, 110→001, 101→000 and 010→101. This holds for all eight starting values.
- R4: With `rst_i` low and `en_i` low, a rising edge leaves `cnt_o` unchanged.
- R5: After reset is released, `cnt_o` stays 000 through edges with `en_i` low. It first becomes 011 on the first enabled edge.
- R6: Starting from 000 with `en_i` held high, successive edges give 3,6,1,4,7,2,5,0. The count is back at its starting value after exactly eight edges.
- R7: `cnt_o` changes only at a rising edge of `clk_i` or on reset. A falling edge never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count updates on its rising edge |
| rst_i | input | 1 | Asynchronous active-high clear |
| en_i | input | 1 | Count enable; high lets an edge add three |
| cnt_o | output | 3 | Current count value |

## Verification
The clocked assertions assume that `en_i` is stable around each rising edge. They also assume that any reset pulse starting mid-period covers at least one rising edge before it is released. A pulse that rose and fell entirely between two edges would make the step and hold properties compare against a count that reset had already cleared. The bench therefore drives `en_i` only at falling edges. It raises reset mid-period and holds it across a following rising edge. Expected counts come from modular arithmetic in the bench, with a sweep over every starting code.

// File: rtl/stride_pkg.sv
package stride_pkg;

    // Operation chosen for the coming clock edge.
    typedef enum logic [0:0] {
        OP_HOLD = 1'b0,
        OP_STEP = 1'b1
    } stride_op_e;

endpackage

// File: rtl/stride_ctl.sv
module stride_ctl
    import stride_pkg::*;
(
    input  logic       en_i,
    output stride_op_e op_o
);

    always_comb begin
        unique case (en_i)
            1'b1:    op_o = OP_STEP;
            default: op_o = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/stride_step.sv
module stride_step #(
    parameter int WIDTH = 3,
    parameter int STEP  = 3
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    // The stride is truncated to the counter width, so the sum wraps
    // modulo 2**WIDTH with no extra logic.
    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    always_comb begin
        nxt_o = cur_i + STEP_W;
    end

endmodule

// File: rtl/stride_reg.sv
module stride_reg
    import stride_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  stride_op_e       op_i,
    input  logic [WIDTH-1:0] nxt_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] q_next;

    // Next-state choice for the coming edge.
    always_comb begin
        unique case (op_i)
            OP_STEP: q_next = nxt_i;
            OP_HOLD: q_next = q_o;
            default: q_next = q_o;
        endcase
    end

    // State register with asynchronous clear.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= q_next;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_HOLD) |=> $stable(q_o));   // R4

endmodule

// File: rtl/stride3_counter.sv
module stride3_counter
    import stride_pkg::*;
#(
    parameter int WIDTH = 3,
    parameter int STEP  = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] cnt_o
);

    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    stride_op_e       op;
    logic [WIDTH-1:0] nxt;

    stride_ctl u_ctl (
        .en_i (en_i),
        .op_o (op)
    );

    stride_step #(
        .WIDTH (WIDTH),
        .STEP  (STEP)
    ) u_step (
        .cur_i (cnt_o),
        .nxt_o (nxt)
    );

    stride_reg #(
        .WIDTH (WIDTH)
    ) u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .op_i  (op),
        .nxt_i (nxt),
        .q_o   (cnt_o)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |-> (cnt_o == '0));                                     // R1

    AST_RESET_OVER_EN: assert property (@(posedge clk_i)
        (rst_i && en_i) |=> (cnt_o == '0));                           // R2

    AST_STRIDE_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (cnt_o == WIDTH'($past(cnt_o) + STEP_W)));           // R3

endmodule

// File: tb/stride3_counter_tb.sv
module stride3_counter_tb;

    logic       clk;
    logic       rst;
    logic       en;
    logic [2:0] cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    stride3_counter u_dut (
        .clk_i (clk),
        .rst_i (rst),
        .en_i  (en),
        .cnt_o (cnt)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [2:0] exp);
        total++;
        if (cnt !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, cnt, exp);
        end
    endtask

    // Drive enable at a falling edge, take one rising edge, sample 1 ns later.
    task automatic tick(input logic e);
        @(negedge clk);
        en = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        en  = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic reach(input int target);
        // 3 is its own inverse mod 8, so 3*target steps land on target.
        do_reset();
        for (int k = 0; k < (target * 3) % 8; k++) tick(1'b1);
    endtask

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        en  = 1'b0;
        #1;
        check("R1 reset at time zero", 3'd0);
        @(posedge clk);
        #1;
        check("R1 reset held", 3'd0);

        // R2: an enabled edge during reset does nothing.
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        #1;
        check("R2 reset over enable", 3'd0);
        @(negedge clk);
        en  = 1'b0;
        rst = 1'b0;

        // R5: after release the count waits for an enabled edge.
        tick(1'b0);
        check("R5 idle after release", 3'd0);
        tick(1'b0);
        check("R5 idle after release", 3'd0);
        tick(1'b1);
        check("R5 first enabled edge", 3'd3);

        // R3 and R4 for every starting value.
        for (int s = 0; s < 8; s++) begin
            reach(s);
            check("R3 reach start", 3'(s));
            tick(1'b0);
            check("R4 hold", 3'(s));
            tick(1'b1);
            check("R3 wrapped step", 3'((s + 3) % 8));
        end

        // R6: full cycle order and return after eight edges.
        do_reset();
        for (int k = 1; k <= 8; k++) begin
            tick(1'b1);
            check("R6 sequence", 3'((3 * k) % 8));
        end

        // R7: a falling edge leaves the count alone.
        @(negedge clk);
        en = 1'b1;
        #1;
        check("R7 no change at falling edge", 3'd0);
        @(posedge clk);
        #1;
        check("R7 change at rising edge", 3'd3);
        @(negedge clk);
        en = 1'b0;

        // R1: reset raised mid-period clears without a clock edge.
        tick(1'b1);
        check("R3 before mid reset", 3'd6);
        @(negedge clk);
        en = 1'b0;
        #2;
        rst = 1'b1;
        #1;
        check("R1 mid-period clear", 3'd0);
        @(posedge clk);
        #1;
        check("R1 held across edge", 3'd0);
        @(negedge clk);
        rst = 1'b0;
        tick(1'b1);
        check("R5 resume after mid reset", 3'd3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule